// File: doc/BRIEF.md
# Zero-Cross Stepped Digital Gain Stage

This block scales one channel of signed 24-bit linear PCM by a programmable gain between -64 dB and +63 dB in 1 dB steps. It does not jump to a new setting. The gain it actually uses walks toward the requested value one decibel at a time. Each step is taken only on a sample where the waveform passes through zero. The result is a volume change without audible steps. If the signal never crosses zero, for example under a held DC offset, a sample-count timeout forces the step anyway.

A soft mute moves the target to the bottom of the range. The gain ramps down through the same stepping rule. Once it reaches -64 dB, the block drives silence. Releasing the mute ramps the gain back up to the programmed value.

Samples enter and leave through valid/ready streams with one register stage between them. A sample is accepted when `in_valid` and `in_ready` are both high, and it appears on `out_data` with `out_valid` one cycle later. `in_ready` follows `out_ready` whenever the output register is full, so back-pressure passes straight through to the input. The output holds its value while it is stalled.

Top module: `pcm_gain_zc`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and the applied gain is 0 dB. With `gain_req` = 0 and `mute_req` low, `gain_settled` is therefore high.
- R2: An accepted sample s is scaled using the gain g in force for that sample. Write g = 6q + r, where q = floor(g/6) and r is in 0..5. The product s·M[r] is taken with M = {32768, 36766, 41253, 46286, 51935, 58271}. Half of 2^(15-q) is added to that product, and the sum is shifted arithmetically right by 15-q. The result is saturated to the range -8388608..8388607.
- R3: An accepted sample counts as a zero crossing if it equals zero or if its sign differs from the sign of the previous accepted sample. Before the first sample, the previous sample counts as non-negative. The applied gain changes only on an accepted sample, and only on a crossing or on a timeout.
- R4: On each step, the applied gain moves exactly 1 dB toward the target. The sample that causes the step is already scaled with the new gain.
- R5: Suppose the applied gain differs from the target for 1024 consecutive accepted samples and none of them is a crossing. Then the 1024th sample forces one step.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. The result of an accepted sample appears one cycle later. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R7: While `mute_req` is high, the target is -64 dB. Any sample processed with mute active and a gain of -64 dB produces 0. When mute is released, the gain steps back up to `gain_req`.
- R8: When `fmt16` is high at acceptance, `out_data` holds bits 23..8 of the saturated result, sign-extended to 24 bits. The low bits are dropped by truncation.
- R9: `gain_settled` is high exactly when the applied gain equals the target: -64 if `mute_req` is high, otherwise `gain_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take the input sample |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | 24 | Signed scaled sample |
| gain_req | input | 7 | Requested gain in dB, signed two's complement |
| mute_req | input | 1 | Soft mute request |
| fmt16 | input | 1 | Select 16-bit output format |
| gain_settled | output | 1 | Applied gain equals target |

## Verification
A behavioural model runs alongside the block and predicts every output sample and the settled flag, each cycle.

- **Unity gain with extreme values** separates the rounding and shifting law from any stepping effect.
- **A long run of same-sign samples** followed by an alternating-sign burst shows that gain moves only on crossings, one decibel at a time.
- **A held positive level longer than two timeout windows** isolates the forced step.
- **Full-scale alternation at high gain** exercises saturation.
- **A mute and unmute cycle** checks the ramp down, the forced silence and the ramp back up.
- **16-bit format** is checked on its own.
- **Irregular valid and ready patterns** show that stalls neither drop nor reorder samples and do not move the gain.

// File: rtl/pcm_gain_pkg.sv
package pcm_gain_pkg;
  localparam int GAIN_W   = 7;
  localparam int MANT_W   = 16;
  localparam int GAIN_MIN = -64;

  typedef logic signed [GAIN_W-1:0] gain_t;

  // Linear factor for 0..5 dB above a power-of-two boundary, scaled by 2^15.
  function automatic logic [MANT_W-1:0] mant_of(input logic [2:0] r);
    case (r)
      3'd0:    mant_of = 16'd32768;
      3'd1:    mant_of = 16'd36766;
      3'd2:    mant_of = 16'd41253;
      3'd3:    mant_of = 16'd46286;
      3'd4:    mant_of = 16'd51935;
      default: mant_of = 16'd58271;
    endcase
  endfunction
endpackage

// File: rtl/gain_tracker.sv
module gain_tracker
  import pcm_gain_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          smp_neg,
  input  logic          smp_zero,
  input  gain_t         target,
  output gain_t         gain_now,
  output gain_t         gain_use,
  output logic [CW-1:0] wait_cnt
);
  logic  prev_neg;
  logic  crossing;
  logic  expired;
  logic  step;
  logic  off_target;

  assign crossing   = smp_zero || (smp_neg != prev_neg);
  assign expired    = (wait_cnt == CW'(TIMEOUT - 1));
  assign off_target = (gain_now != target);
  assign step       = off_target && (crossing || expired);

  always_comb begin
    gain_use = gain_now;
    if (step) begin
      if (target > gain_now) gain_use = gain_now + 7'sd1;
      else                   gain_use = gain_now - 7'sd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_now <= '0;
      prev_neg <= 1'b0;
      wait_cnt <= '0;
    end else if (fire) begin
      gain_now <= gain_use;
      prev_neg <= smp_neg;
      if (step || !off_target) wait_cnt <= '0;
      else                     wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import pcm_gain_pkg::*;
#(
  parameter int DW = 24,
  parameter int NW = 16,
  localparam int PW = DW + MANT_W + 1
) (
  input  logic signed [DW-1:0] sample,
  input  gain_t                gain,
  input  logic                 silence,
  input  logic                 narrow,
  output logic signed [DW-1:0] result
);
  logic [7:0]           g_ofs;
  logic [4:0]           q_ofs;
  logic [2:0]           r_ofs;
  logic [4:0]           sh;
  logic [MANT_W-1:0]    mant;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] scaled;
  logic                 pos_ovf;
  logic                 neg_ovf;
  logic signed [DW-1:0] sat;
  logic signed [DW-1:0] fmt_out;

  // Offset by 66 (a multiple of 6) so the floor division stays unsigned.
  always_comb begin
    g_ofs = {gain[GAIN_W-1], gain} + 8'd66;
    q_ofs = 5'(g_ofs / 8'd6);
    r_ofs = 3'(g_ofs % 8'd6);
    sh    = 5'd26 - q_ofs;
  end

  assign mant   = mant_of(r_ofs);
  assign prod   = sample * $signed({1'b0, mant});
  assign rnd    = prod + ({{(PW-1){1'b0}}, 1'b1} << (sh - 5'd1));
  assign scaled = rnd >>> sh;

  assign pos_ovf = !scaled[PW-1] && (|scaled[PW-2:DW-1]);
  assign neg_ovf =  scaled[PW-1] && !(&scaled[PW-2:DW-1]);

  always_comb begin
    if (pos_ovf)      sat = {1'b0, {(DW-1){1'b1}}};
    else if (neg_ovf) sat = {1'b1, {(DW-1){1'b0}}};
    else              sat = scaled[DW-1:0];
  end

  generate
    if (NW < DW) begin : g_narrow
      assign fmt_out = narrow ? {{(DW-NW){sat[DW-1]}}, sat[DW-1:DW-NW]} : sat;
    end else begin : g_full
      assign fmt_out = sat;
    end
  endgenerate

  assign result = silence ? '0 : fmt_out;
endmodule

// File: rtl/pcm_gain_zc.sv
module pcm_gain_zc
  import pcm_gain_pkg::*;
#(
  parameter int DW      = 24,
  parameter int NW      = 16,
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [6:0]    gain_req,
  input  logic          mute_req,
  input  logic          fmt16,
  output logic          gain_settled
);
  gain_t                target;
  gain_t                gain_now;
  gain_t                gain_use;
  logic [CW-1:0]        wait_cnt;
  logic                 fire;
  logic                 silence;
  logic signed [DW-1:0] result;

  assign in_ready     = !out_valid || out_ready;
  assign fire         = in_valid && in_ready;
  assign target       = mute_req ? gain_t'(GAIN_MIN) : $signed(gain_req);
  assign silence      = mute_req && (gain_use == gain_t'(GAIN_MIN));
  assign gain_settled = (gain_now == target);

  gain_tracker #(.TIMEOUT(TIMEOUT)) i_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .smp_neg  (in_data[DW-1]),
    .smp_zero (in_data == '0),
    .target   (target),
    .gain_now (gain_now),
    .gain_use (gain_use),
    .wait_cnt (wait_cnt)
  );

  gain_scaler #(.DW(DW), .NW(NW)) i_scale (
    .sample  ($signed(in_data)),
    .gain    (gain_use),
    .silence (silence),
    .narrow  (fmt16),
    .result  (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_gain_zc_chk.sv
module pcm_gain_zc_chk
  import pcm_gain_pkg::*;
#(
  parameter int DW      = 24,
  parameter int TIMEOUT = 1024,
  parameter int CW      = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          mute_req,
  input gain_t         gain_now,
  input logic [CW-1:0] wait_cnt
);
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_now == $past(gain_now)) || (gain_now == $past(gain_now) + 7'sd1) ||
    (gain_now == $past(gain_now) - 7'sd1));

  a_r3_step_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_now) |-> $past(in_valid && in_ready));

  a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt < CW'(TIMEOUT));

  a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mute_req && gain_now == gain_t'(GAIN_MIN)) |=> (out_data == '0));
endmodule

bind pcm_gain_zc pcm_gain_zc_chk #(.DW(DW), .TIMEOUT(TIMEOUT), .CW(CW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .mute_req  (mute_req),
  .gain_now  (gain_now),
  .wait_cnt  (wait_cnt)
);

// File: tb/test_pcm_gain_zc.sv
`timescale 1ns/1ps
module test_pcm_gain_zc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;
  logic [6:0]  gain_req = '0;
  logic        mute_req = 1'b0;
  logic        fmt16 = 1'b0;
  logic        gain_settled;

  int checks = 0;
  int errors = 0;
  string ph = "R2";

  int MT[6] = '{32768, 36766, 41253, 46286, 51935, 58271};
  int m_app = 0;
  bit m_prev_neg = 1'b0;
  int m_cnt = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  pcm_gain_zc i_pcm_gain_zc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .gain_req(gain_req), .mute_req(mute_req),
    .fmt16(fmt16), .gain_settled(gain_settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int scale(input int s, input int g, input bit sil, input bit f16);
    int q, r, sh;
    longint p;
    if (sil) return 0;
    q  = (g + 66) / 6 - 11;
    r  = (g + 66) % 6;
    sh = 15 - q;
    p  = longint'(s) * MT[r];
    p  = (p + (longint'(1) <<< (sh - 1))) >>> sh;
    if (p > 8388607)  p = 8388607;
    if (p < -8388608) p = -8388608;
    if (f16) p = p >>> 8;
    return int'(p);
  endfunction

  function automatic int target_now();
    return mute_req ? -64 : int'($signed(gain_req));
  endfunction

  // One bench cycle: inputs set just after a rising edge, checked at the falling edge.
  task automatic cyc(input bit v, input int s, input bit ordy);
    int tg, use_g, e, sv;
    bit zc, stp;
    in_valid  = v;
    in_data   = 24'(s);
    out_ready = ordy;
    @(negedge clk);
    chk(in_ready == (!out_valid || out_ready), "R6", int'(in_ready), int'(!out_valid || out_ready));
    chk(out_valid == (exp_q.size() > 0), "R6", int'(out_valid), exp_q.size());
    if (out_valid && exp_q.size() > 0)
      chk(int'($signed(out_data)) == exp_q[0], ph, int'($signed(out_data)), exp_q[0]);
    chk(gain_settled == (m_app == target_now()), "R9", int'(gain_settled), int'(m_app == target_now()));
    if (out_valid && out_ready && exp_q.size() > 0) void'(exp_q.pop_front());
    if (in_valid && in_ready) begin
      sv    = int'($signed(in_data));
      tg    = target_now();
      zc    = (sv == 0) || ((sv < 0) != m_prev_neg);
      stp   = (m_app != tg) && (zc || m_cnt == 1023);
      use_g = stp ? m_app + ((tg > m_app) ? 1 : -1) : m_app;
      m_cnt = (stp || m_app == tg) ? 0 : m_cnt + 1;
      m_app = use_g;
      m_prev_neg = (sv < 0);
      e = scale(sv, use_g, mute_req && use_g == -64, fmt16);
      exp_q.push_back(e);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic alt(input int n, input int amp);
    for (int i = 0; i < n; i++) cyc(1'b1, (i % 2 == 0) ? -amp : amp, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(gain_settled == 1'b1, "R1", int'(gain_settled), 1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R2: unity gain with extremes
    ph = "R2";
    cyc(1, 100, 1); cyc(1, -100, 1); cyc(1, 0, 1);
    cyc(1, 8388607, 1); cyc(1, -8388608, 1); cyc(1, 12345, 1);

    // R3: no crossing, no step
    ph = "R3";
    gain_req = 7'sd6;
    for (int i = 0; i < 20; i++) cyc(1, 1000, 1);
    chk(gain_settled == 1'b0, "R3", int'(gain_settled), 0);
    // R4: one step per crossing
    ph = "R4";
    alt(10, 500000);
    chk(gain_settled == 1'b1, "R4", int'(gain_settled), 1);

    // R2: saturation at high gain
    ph = "R2";
    gain_req = 7'sd63;
    alt(70, 4000000);

    // R5: timeout under a held level
    ph = "R5";
    gain_req = 7'sd50;
    for (int i = 0; i < 2100; i++) cyc(1, 300000, 1);
    chk(m_app == 61, "R5", m_app, 61);

    // R7: mute ramp, silence, release
    ph = "R7";
    mute_req = 1'b1;
    alt(140, 200000);
    chk(gain_settled == 1'b1, "R7", int'(gain_settled), 1);
    cyc(1, 7777, 1);
    cyc(0, 0, 1);
    chk(out_data == 24'd0, "R7", int'($signed(out_data)), 0);
    mute_req = 1'b0;
    gain_req = 7'sd3;
    alt(80, 200000);
    chk(gain_settled == 1'b1, "R7", int'(gain_settled), 1);

    // R8: 16-bit format
    ph = "R8";
    fmt16 = 1'b1;
    alt(6, 3000000);
    cyc(1, 8388607, 1); cyc(1, -8388608, 1); cyc(1, 255, 1);
    fmt16 = 1'b0;

    // R6: irregular valid/ready with gain moving
    ph = "R6";
    gain_req = -7'sd10;
    for (int i = 0; i < 300; i++)
      cyc((i % 4) != 1, (i % 3 == 0) ? -40000 - i : 40000 + i, (i % 3) != 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule